// File: doc/BRIEF.md
# Accumulator Execution Unit

This block executes one-address instructions in a single-accumulator organisation. Each instruction carries an operation code and one direct memory address. The accumulator is the implied second source and the only destination for every data operation, so a program that needs an intermediate value must spill it to memory with a store and read it back later. The unit holds a 64-word, 16-bit data memory and exposes the accumulator and a zero flag.

Instructions arrive on a valid/ready stream. An instruction transfers on a rising clock edge where both `ins_valid` and `ins_ready` are high, and the unit executes it in that same edge. `ins_ready` is low only while the host memory port is writing, which gives the host write priority over execution. A sender that sees `ins_ready` low must hold its instruction steady and present it again. The host port writes the memory at the clock edge. Its read port is combinational, so a testbench or loader can preload operands and inspect results.

Top module: `acc_exec_unit`

## Requirements
- R1: An accepted LOAD (`ins_op` = 2'b00) sets the accumulator to the word at `ins_addr`. The new value is visible on `acc_out` after the accepting edge.
- R2: An accepted ADD (`ins_op` = 2'b10) sets the accumulator to the accumulator plus the addressed word, modulo 2^16.
- R3: An accepted MUL (`ins_op` = 2'b11) sets the accumulator to the low 16 bits of the accumulator times the addressed word.
- R4: An accepted STORE (`ins_op` = 2'b01) writes the accumulator into the addressed word at the accepting edge and leaves the accumulator unchanged.
- R5: When no instruction is accepted on an edge, the accumulator holds its value.
- R6: `ins_ready` is low exactly while `host_wr_en` is high. An instruction offered in such a cycle does not execute.
- R7: `acc_zero` is high exactly when `acc_out` is zero, and it changes on the same edge as `acc_out`.
- R8: Reset (`rst_n` low) clears the accumulator and raises `acc_zero`.
- R9: The stream LOAD A, ADD B, STORE T, LOAD C, ADD D, MUL T, STORE X leaves (A+B)*(C+D), modulo 2^16, in word X.
- R10: `host_rd_data` shows the word at `host_rd_addr` in the same cycle, including a word written on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset for the accumulator |
| ins_valid | input | 1 | An instruction is offered |
| ins_ready | output | 1 | The unit can accept an instruction this cycle |
| ins_op | input | 2 | Operation: 00 LOAD, 01 STORE, 10 ADD, 11 MUL |
| ins_addr | input | 6 | Direct memory operand address |
| host_wr_en | input | 1 | Host memory write strobe |
| host_wr_addr | input | 6 | Host write address |
| host_wr_data | input | 16 | Host write data |
| host_rd_addr | input | 6 | Host read address |
| host_rd_data | output | 16 | Word at host_rd_addr, combinational |
| acc_out | output | 16 | Accumulator value |
| acc_zero | output | 1 | High when the accumulator is zero |

## Verification
Every accumulator result and every store is due one edge after the instruction is accepted. `ins_ready` and `host_rd_data` are combinational and are due in the same cycle. The bench drives inputs at the falling edge and predicts the effect of the coming rising edge with a behavioural model. It then compares `acc_out` and `acc_zero` at the following falling edge, one full edge after acceptance. It checks `ins_ready` in the drive cycle. It reads memory back through the host port at that same falling edge, so the result of a store is observed on the first cycle it is due.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 6;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_ADD   = 2'b10,
    OP_MUL   = 2'b11
  } acc_op_e;
endpackage

// File: rtl/acc_dmem.sv
module acc_dmem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_addr] <= wr_data;
  end

  // Two independent asynchronous read ports: operand fetch and host view.
  assign rd_a_data = words[rd_a_addr];
  assign rd_b_data = words[rd_b_addr];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  acc_op_e           op,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opd_i,
  output logic [DATA_W-1:0] acc_next
);
  logic [DATA_W-1:0] sum_lo;
  logic [DATA_W-1:0] prod_lo;

  // Self-determined widths keep the arithmetic modulo 2^DATA_W.
  assign sum_lo  = acc_i + opd_i;
  assign prod_lo = acc_i * opd_i;

  always_comb begin
    unique case (op)
      OP_LOAD:  acc_next = opd_i;
      OP_ADD:   acc_next = sum_lo;
      OP_MUL:   acc_next = prod_lo;
      default:  acc_next = acc_i;   // STORE leaves the accumulator alone
    endcase
  end
endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] next_val,
  output logic [DATA_W-1:0] acc_q,
  output logic              zero_q
);
  // The zero flag is registered from the incoming value, so it is ready
  // on the same edge as the accumulator without a compare on the output.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      zero_q <= 1'b1;
    end else if (load_en) begin
      acc_q  <= next_val;
      zero_q <= (next_val == '0);
    end
  end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_pkg::*;
#(
  parameter int unsigned DW = acc_pkg::DATA_W,
  parameter int unsigned AW = acc_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [1:0]    ins_op,
  input  logic [AW-1:0] ins_addr,
  input  logic          host_wr_en,
  input  logic [AW-1:0] host_wr_addr,
  input  logic [DW-1:0] host_wr_data,
  input  logic [AW-1:0] host_rd_addr,
  output logic [DW-1:0] host_rd_data,
  output logic [DW-1:0] acc_out,
  output logic          acc_zero
);
  acc_op_e       op;
  logic          fire;
  logic          store_fire;
  logic [DW-1:0] opd;
  logic [DW-1:0] acc_next;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;

  assign op         = acc_op_e'(ins_op);
  assign ins_ready  = !host_wr_en;
  assign fire       = ins_valid && ins_ready;
  assign store_fire = fire && (op == OP_STORE);

  // The host and a store never write on the same edge: a host write holds
  // ins_ready low, so the mux needs no arbitration.
  assign mem_we    = host_wr_en || store_fire;
  assign mem_waddr = host_wr_en ? host_wr_addr : ins_addr;
  assign mem_wdata = host_wr_en ? host_wr_data : acc_out;

  acc_dmem #(.DATA_W(DW), .ADDR_W(AW)) u_mem (
    .clk       (clk),
    .wr_en     (mem_we),
    .wr_addr   (mem_waddr),
    .wr_data   (mem_wdata),
    .rd_a_addr (ins_addr),
    .rd_a_data (opd),
    .rd_b_addr (host_rd_addr),
    .rd_b_data (host_rd_data)
  );

  acc_alu #(.DATA_W(DW)) u_alu (
    .op       (op),
    .acc_i    (acc_out),
    .opd_i    (opd),
    .acc_next (acc_next)
  );

  acc_reg #(.DATA_W(DW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (fire),
    .next_val (acc_next),
    .acc_q    (acc_out),
    .zero_q   (acc_zero)
  );
endmodule

// File: rtl/acc_exec_checker.sv
module acc_exec_checker #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ins_valid,
  input logic          ins_ready,
  input logic [1:0]    ins_op,
  input logic          host_wr_en,
  input logic [DW-1:0] op_data,
  input logic [DW-1:0] acc_out,
  input logic          acc_zero
);
  logic          fire;
  logic [DW-1:0] exp_sum;
  logic [DW-1:0] exp_prod;

  assign fire     = ins_valid && ins_ready;
  assign exp_sum  = acc_out + op_data;
  assign exp_prod = acc_out * op_data;

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ins_op == 2'b00) |=> acc_out == $past(op_data));

  p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ins_op == 2'b10) |=> acc_out == $past(exp_sum));

  p_mul_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ins_op == 2'b11) |=> acc_out == $past(exp_prod));

  p_store_keeps_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ins_op == 2'b01) |=> $stable(acc_out));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(acc_out));

  p_host_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en |-> !ins_ready);

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_zero == (acc_out == '0));

  p_reset_clear_r8: assert property (@(posedge clk)
    $rose(rst_n) |-> (acc_out == '0 && acc_zero));
endmodule

bind acc_exec_unit acc_exec_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ins_valid  (ins_valid),
  .ins_ready  (ins_ready),
  .ins_op     (ins_op),
  .host_wr_en (host_wr_en),
  .op_data    (opd),
  .acc_out    (acc_out),
  .acc_zero   (acc_zero)
);

// File: tb/tb_acc_exec_unit.sv
`timescale 1ns/1ps
module tb_acc_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [1:0]  ins_op = 2'b00;
  logic [5:0]  ins_addr = '0;
  logic        host_wr_en = 1'b0;
  logic [5:0]  host_wr_addr = '0;
  logic [15:0] host_wr_data = '0;
  logic [5:0]  host_rd_addr = '0;
  logic [15:0] host_rd_data;
  logic [15:0] acc_out;
  logic        acc_zero;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  logic [15:0] m_mem [64];
  logic [15:0] m_acc;

  always #2 clk = ~clk;

  acc_exec_unit dut (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_op(ins_op), .ins_addr(ins_addr),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
    .host_wr_data(host_wr_data), .host_rd_addr(host_rd_addr),
    .host_rd_data(host_rd_data), .acc_out(acc_out), .acc_zero(acc_zero)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive after a falling edge, model the next rising edge,
  // compare at the following falling edge.
  task automatic step(input logic we, input logic [5:0] wa, input logic [15:0] wd,
                      input logic v, input logic [1:0] op, input logic [5:0] a,
                      input string req);
    logic fire;
    logic [15:0] opd;
    host_wr_en = we; host_wr_addr = wa; host_wr_data = wd;
    ins_valid = v; ins_op = op; ins_addr = a;
    #0.5;
    check({req, " R6 ready"}, {15'd0, ins_ready}, {15'd0, !we});
    fire = v && !we;
    opd = m_mem[a];
    if (we) m_mem[wa] = wd;
    if (fire) begin
      case (op)
        2'b00: m_acc = opd;
        2'b01: m_mem[a] = m_acc;
        2'b10: m_acc = m_acc + opd;
        default: m_acc = m_acc * opd;
      endcase
    end
    @(negedge clk);
    host_wr_en = 1'b0; ins_valid = 1'b0;
    check({req, " acc"}, acc_out, m_acc);
    check({req, " R7 zero"}, {15'd0, acc_zero}, {15'd0, m_acc == 16'd0});
  endtask

  task automatic peek(input logic [5:0] a, input string req);
    host_rd_addr = a;
    #0.5;
    check(req, host_rd_data, m_mem[a]);
  endtask

  task automatic poke(input logic [5:0] a, input logic [15:0] d);
    step(1'b1, a, d, 1'b0, 2'b00, 6'd0, "R10 preload");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = 16'd0;
    m_acc = 16'd0;
    repeat (3) @(negedge clk);
    check("R8 reset acc", acc_out, 16'd0);
    check("R8 reset zero", {15'd0, acc_zero}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", acc_out, 16'd0);

    // Clear the used words, then preload operands
    for (int i = 0; i < 16; i++) poke(6'(i), 16'd0);
    poke(6'd1, 16'hFFFF);
    poke(6'd2, 16'h0002);
    poke(6'd3, 16'h1234);
    poke(6'd4, 16'h0100);
    poke(6'd5, 16'h00AA);
    peek(6'd3, "R10 read back");

    step(0, 0, 0, 1, 2'b00, 6'd1, "R1 load");
    step(0, 0, 0, 1, 2'b10, 6'd2, "R2 add wrap");     // FFFF+2 = 0001
    step(0, 0, 0, 1, 2'b10, 6'd1, "R2 add to zero");  // 0001+FFFF = 0000
    step(0, 0, 0, 1, 2'b00, 6'd3, "R1 load");
    step(0, 0, 0, 1, 2'b11, 6'd4, "R3 mul wrap");     // 1234*0100 = 3400
    step(0, 0, 0, 1, 2'b01, 6'd6, "R4 store");
    peek(6'd6, "R4 stored word");
    step(0, 0, 0, 1, 2'b00, 6'd4, "R1 load");
    step(0, 0, 0, 1, 2'b11, 6'd4, "R3 mul to zero");  // 0100*0100 = 0

    step(0, 0, 0, 1, 2'b00, 6'd5, "R1 load");
    step(0, 0, 0, 0, 2'b00, 6'd1, "R5 idle hold");
    step(0, 0, 0, 0, 2'b11, 6'd4, "R5 idle hold");
    // Host write blocks an offered instruction
    step(1, 6'd7, 16'h0055, 1, 2'b00, 6'd1, "R6 blocked load");
    peek(6'd7, "R6 host write landed");
    step(1, 6'd8, 16'h0009, 1, 2'b01, 6'd9, "R6 blocked store");
    peek(6'd9, "R6 store suppressed");

    // Spill-through-memory program: A=10 B=11 C=12 D=13 T=14 X=15
    poke(6'd10, 16'd3); poke(6'd11, 16'd4);
    poke(6'd12, 16'd5); poke(6'd13, 16'd6);
    step(0, 0, 0, 1, 2'b00, 6'd10, "R9 load A");
    step(0, 0, 0, 1, 2'b10, 6'd11, "R9 add B");
    step(0, 0, 0, 1, 2'b01, 6'd14, "R9 store T");
    step(0, 0, 0, 1, 2'b00, 6'd12, "R9 load C");
    step(0, 0, 0, 1, 2'b10, 6'd13, "R9 add D");
    step(0, 0, 0, 1, 2'b11, 6'd14, "R9 mul T");
    step(0, 0, 0, 1, 2'b01, 6'd15, "R9 store X");
    host_rd_addr = 6'd15;
    #0.5;
    check("R9 result at X", host_rd_data, 16'd77);
    check("R9 model agrees", m_mem[15], 16'd77);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule